// File: doc/BRIEF.md
# Eight-Bit Accumulator ALU with Status Flags

This block is the arithmetic and logic stage of a small eight-bit accumulator datapath. Each cycle it takes an accumulator value, a second operand, the current carry, auxiliary-carry and overflow flags, and a four-bit operation code. It computes a new eight-bit result and a new flag set. Result and flags are registered once at the output, so the answer to an operation presented in one cycle appears after the next rising clock edge.

The operations cover:
- binary addition, with or without the incoming carry;
- subtraction that consumes the carry as a borrow;
- increment and decrement;
- the bitwise AND, OR and XOR operations, clear and complement;
- four single-bit rotations, two of them passing through the carry;
- a two-step decimal correction that turns the sum of two packed BCD bytes back into packed BCD.

Flags an operation does not define pass through from the inputs unchanged. The parity output always reflects the new result. Operand fetch and flag storage belong to the surrounding datapath.

Top module: `alu8_core`

## Requirements
- R1: While rst_n is low, res_o, cy_o, ac_o, ov_o and par_o are all 0.
- R2: Each output reflects the inputs present at the previous rising clock edge. op_i encodes 0 add, 1 add with carry, 2 subtract with borrow, 3 increment, 4 decrement, 5 AND, 6 OR, 7 XOR, 8 clear, 9 complement, 10 rotate left, 11 rotate left through carry, 12 rotate right, 13 rotate right through carry, 14 decimal adjust, 15 pass.
- R3: Add gives (acc_i + src_i) mod 256, and add with carry also adds cy_i. cy_o is set exactly when the true sum exceeds 255.
- R4: On add and add with carry, ac_o is set when the low nibbles plus incoming carry exceed 15. On subtract, ac_o is set when the low nibble of acc_i is smaller than the low nibble of src_i plus cy_i.
- R5: On add, add with carry and subtract, ov_o is set exactly when the carry into bit 7 differs from the carry out of bit 7. Equivalently, it is set when the two's-complement result falls outside -128..127.
- R6: Subtract gives (acc_i - src_i - cy_i) mod 256. cy_o is set when a borrow is needed, that is when acc_i < src_i + cy_i.
- R7: For every operation, par_o is 1 when res_o holds an odd number of ones and 0 otherwise.
- R8: Increment and decrement wrap modulo 256 and copy cy_i, ac_i and ov_i to the outputs unchanged.
- R9: AND, OR and XOR combine acc_i with src_i bitwise, clear gives 0, and complement gives the inverse of acc_i. All five copy cy_i, ac_i and ov_i unchanged.
- R10: Rotate left moves bit 7 into bit 0 and rotate right moves bit 0 into bit 7, with carry unchanged. Rotate left through carry gives {acc_i[6:0], cy_i} with cy_o = acc_i[7]. Rotate right through carry gives {cy_i, acc_i[7:1]} with cy_o = acc_i[0]. AC and OV are unchanged by all four.
- R11: Decimal adjust first adds 06h when acc_i[3:0] > 9 or ac_i is set. It then adds 60h when the high nibble of that value is > 9, or cy_i is set, or the first step carried out. cy_o is set when cy_i was set or either step carried out. AC and OV are unchanged.
- R12: Pass gives acc_i with cy, ac and ov unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 4 | Operation code |
| acc_i | input | 8 | Accumulator operand |
| src_i | input | 8 | Second operand |
| cy_i | input | 1 | Incoming carry flag |
| ac_i | input | 1 | Incoming auxiliary-carry flag |
| ov_i | input | 1 | Incoming overflow flag |
| res_o | output | 8 | Registered result |
| cy_o | output | 1 | Registered carry flag |
| ac_o | output | 1 | Registered auxiliary-carry flag |
| ov_o | output | 1 | Registered overflow flag |
| par_o | output | 1 | Registered parity of the result |

## Verification
Every operation, including the two-step decimal correction, is due exactly one rising edge after its inputs are applied, because the whole datapath sits in front of a single output register. The driver applies one operation per clock on the falling edge and queues its expected result. The monitor wakes one time unit after each rising edge and pops exactly one queued item per clock. A result that appeared a cycle early or late would therefore be compared against the wrong item. The operand set exercises the carry, borrow, nibble and signed-overflow boundaries, and also BCD sums that need one, both or neither decimal correction.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    localparam int DATA_W = 8;
    localparam int NIB_W  = DATA_W / 2;
    localparam int OP_W   = 4;
    localparam logic [NIB_W-1:0] BCD_MAX = NIB_W'(9);

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 4'd0,
        OP_ADDC = 4'd1,
        OP_SUBB = 4'd2,
        OP_INC  = 4'd3,
        OP_DEC  = 4'd4,
        OP_AND  = 4'd5,
        OP_OR   = 4'd6,
        OP_XOR  = 4'd7,
        OP_CLR  = 4'd8,
        OP_CPL  = 4'd9,
        OP_RL   = 4'd10,
        OP_RLC  = 4'd11,
        OP_RR   = 4'd12,
        OP_RRC  = 4'd13,
        OP_DA   = 4'd14,
        OP_PASS = 4'd15
    } op_e;

    typedef struct packed {
        logic [DATA_W-1:0] res;
        logic              cy;
        logic              ac;
        logic              ov;
        logic              par;
    } alu_out_t;

endpackage

// File: rtl/alu8_addsub.sv
// Shared adder for add, add-with-carry and subtract-with-borrow.
// Subtraction is a + ~b + ~cin; borrows are the inverted carries.
module alu8_addsub
    import alu8_pkg::*;
(
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              cin_i,
    input  logic              sub_i,
    output logic [DATA_W-1:0] sum_o,
    output logic              cy_o,
    output logic              ac_o,
    output logic              ov_o
);
    localparam int MID_W = DATA_W - NIB_W - 1;

    logic [DATA_W-1:0] b_eff;
    logic              c_eff;
    logic [NIB_W:0]    lo_sum;
    logic [MID_W:0]    mid_sum;
    logic [1:0]        top_sum;
    logic              c_nib;
    logic              c_msb_in;
    logic              c_msb_out;

    always_comb begin
        b_eff   = sub_i ? ~b_i : b_i;
        c_eff   = sub_i ? ~cin_i : cin_i;
        lo_sum  = {1'b0, a_i[NIB_W-1:0]} + {1'b0, b_eff[NIB_W-1:0]}
                + {{NIB_W{1'b0}}, c_eff};
        c_nib   = lo_sum[NIB_W];
        mid_sum = {1'b0, a_i[DATA_W-2:NIB_W]} + {1'b0, b_eff[DATA_W-2:NIB_W]}
                + {{MID_W{1'b0}}, c_nib};
        c_msb_in  = mid_sum[MID_W];
        top_sum   = {1'b0, a_i[DATA_W-1]} + {1'b0, b_eff[DATA_W-1]}
                  + {1'b0, c_msb_in};
        c_msb_out = top_sum[1];
        sum_o = {top_sum[0], mid_sum[MID_W-1:0], lo_sum[NIB_W-1:0]};
        cy_o  = sub_i ? ~c_msb_out : c_msb_out;
        ac_o  = sub_i ? ~c_nib : c_nib;
        ov_o  = c_msb_in ^ c_msb_out;
    end
endmodule

// File: rtl/alu8_shlog.sv
// Bitwise logic, clear, complement and the four rotations.
module alu8_shlog
    import alu8_pkg::*;
(
    input  op_e               op_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              cy_i,
    output logic [DATA_W-1:0] res_o,
    output logic              cy_o
);
    always_comb begin
        res_o = a_i;
        cy_o  = cy_i;
        unique case (op_i)
            OP_AND: res_o = a_i & b_i;
            OP_OR:  res_o = a_i | b_i;
            OP_XOR: res_o = a_i ^ b_i;
            OP_CLR: res_o = '0;
            OP_CPL: res_o = ~a_i;
            OP_RL:  res_o = {a_i[DATA_W-2:0], a_i[DATA_W-1]};
            OP_RR:  res_o = {a_i[0], a_i[DATA_W-1:1]};
            OP_RLC: begin
                res_o = {a_i[DATA_W-2:0], cy_i};
                cy_o  = a_i[DATA_W-1];
            end
            OP_RRC: begin
                res_o = {cy_i, a_i[DATA_W-1:1]};
                cy_o  = a_i[0];
            end
            default: begin
                res_o = a_i;
                cy_o  = cy_i;
            end
        endcase
    end
endmodule

// File: rtl/alu8_decadj.sv
// Two-step packed-BCD correction after an addition.
module alu8_decadj
    import alu8_pkg::*;
(
    input  logic [DATA_W-1:0] a_i,
    input  logic              cy_i,
    input  logic              ac_i,
    output logic [DATA_W-1:0] res_o,
    output logic              cy_o
);
    localparam logic [DATA_W:0] LO_FIX = (DATA_W+1)'(6);
    localparam logic [DATA_W:0] HI_FIX = (DATA_W+1)'(6) << NIB_W;

    logic            lo_need;
    logic            hi_need;
    logic [DATA_W:0] step1;
    logic [DATA_W:0] step2;

    always_comb begin
        lo_need = (a_i[NIB_W-1:0] > BCD_MAX) || ac_i;
        step1   = {1'b0, a_i} + (lo_need ? LO_FIX : '0);
        hi_need = (step1[DATA_W-1:NIB_W] > BCD_MAX) || cy_i || step1[DATA_W];
        step2   = {1'b0, step1[DATA_W-1:0]} + (hi_need ? HI_FIX : '0);
        res_o   = step2[DATA_W-1:0];
        cy_o    = cy_i | step1[DATA_W] | step2[DATA_W];
    end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OP_W-1:0]   op_i,
    input  logic [DATA_W-1:0] acc_i,
    input  logic [DATA_W-1:0] src_i,
    input  logic              cy_i,
    input  logic              ac_i,
    input  logic              ov_i,
    output logic [DATA_W-1:0] res_o,
    output logic              cy_o,
    output logic              ac_o,
    output logic              ov_o,
    output logic              par_o
);
    op_e op;
    assign op = op_e'(op_i);

    logic              is_sub;
    logic              as_cin;
    logic [DATA_W-1:0] as_sum;
    logic              as_cy, as_ac, as_ov;
    logic [DATA_W-1:0] sl_res;
    logic              sl_cy;
    logic [DATA_W-1:0] da_res;
    logic              da_cy;

    assign is_sub = (op == OP_SUBB);
    assign as_cin = (op == OP_ADD) ? 1'b0 : cy_i;

    alu8_addsub u_addsub (
        .a_i   (acc_i),
        .b_i   (src_i),
        .cin_i (as_cin),
        .sub_i (is_sub),
        .sum_o (as_sum),
        .cy_o  (as_cy),
        .ac_o  (as_ac),
        .ov_o  (as_ov)
    );

    alu8_shlog u_shlog (
        .op_i  (op),
        .a_i   (acc_i),
        .b_i   (src_i),
        .cy_i  (cy_i),
        .res_o (sl_res),
        .cy_o  (sl_cy)
    );

    alu8_decadj u_decadj (
        .a_i   (acc_i),
        .cy_i  (cy_i),
        .ac_i  (ac_i),
        .res_o (da_res),
        .cy_o  (da_cy)
    );

    alu_out_t out_d, out_q;

    always_comb begin
        out_d.res = acc_i;
        out_d.cy  = cy_i;
        out_d.ac  = ac_i;
        out_d.ov  = ov_i;
        unique case (op)
            OP_ADD, OP_ADDC, OP_SUBB: begin
                out_d.res = as_sum;
                out_d.cy  = as_cy;
                out_d.ac  = as_ac;
                out_d.ov  = as_ov;
            end
            OP_INC: out_d.res = acc_i + DATA_W'(1);
            OP_DEC: out_d.res = acc_i - DATA_W'(1);
            OP_AND, OP_OR, OP_XOR, OP_CLR, OP_CPL,
            OP_RL, OP_RLC, OP_RR, OP_RRC: begin
                out_d.res = sl_res;
                out_d.cy  = sl_cy;
            end
            OP_DA: begin
                out_d.res = da_res;
                out_d.cy  = da_cy;
            end
            default: out_d.res = acc_i;
        endcase
        out_d.par = ^out_d.res;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign res_o = out_q.res;
    assign cy_o  = out_q.cy;
    assign ac_o  = out_q.ac;
    assign ov_o  = out_q.ov;
    assign par_o = out_q.par;
endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk
    import alu8_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [OP_W-1:0]   op_i,
    input logic [DATA_W-1:0] acc_i,
    input logic [DATA_W-1:0] src_i,
    input logic              cy_i,
    input logic              ac_i,
    input logic              ov_i,
    input logic [DATA_W-1:0] res_o,
    input logic              cy_o,
    input logic              ac_o,
    input logic              ov_o,
    input logic              par_o
);
    logic armed_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    // R1: outputs are cleared while reset is held
    always_comb begin
        if (rst_n === 1'b0) begin
            a_reset_r1: assert ({res_o, cy_o, ac_o, ov_o, par_o} == '0);
        end
    end

    // R7
    p_parity_r7: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q |-> (par_o == ^res_o));

    // R8
    p_incdec_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && ($past(op_i) == OP_INC || $past(op_i) == OP_DEC)
        |-> (cy_o == $past(cy_i)) && (ac_o == $past(ac_i)) && (ov_o == $past(ov_i)));

    // R9
    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && ($past(op_i) == OP_CLR) |-> (res_o == '0) && (cy_o == $past(cy_i)));

    // R10
    p_rlc_r10: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && ($past(op_i) == OP_RLC)
        |-> (cy_o == $past(acc_i[DATA_W-1])) && (res_o[0] == $past(cy_i))
            && (ac_o == $past(ac_i)) && (ov_o == $past(ov_i)));

    // R11
    p_da_keeps_cy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && ($past(op_i) == OP_DA) && $past(cy_i) |-> cy_o);

    // R3
    p_add_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && ($past(op_i) == OP_ADD) && ($past(src_i) == '0)
        |-> (res_o == $past(acc_i)) && !cy_o);
endmodule

bind alu8_core alu8_core_chk chk_i (.*);

// File: tb/alu8_core_tb_top.sv
module alu8_core_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] op_i = '0;
    logic [7:0] acc_i = '0, src_i = '0;
    logic       cy_i = 1'b0, ac_i = 1'b0, ov_i = 1'b0;
    logic [7:0] res_o;
    logic       cy_o, ac_o, ov_o, par_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [11:0] exp_q[$];
    int          op_q[$];

    always #5 clk = ~clk;

    alu8_core dut_i (.*);

    // Reference model written from the requirements with integer arithmetic.
    function automatic logic [11:0] model(int op, int a, int b, int c, int h, int v);
        int r, cy, ac, ov, sa, sb, t;
        r = a; cy = c; ac = h; ov = v;
        sa = (a > 127) ? a - 256 : a;
        sb = (b > 127) ? b - 256 : b;
        case (op)
            0, 1: begin // R3 R4 R5
                t = (op == 1) ? c : 0;
                r  = a + b + t;
                cy = (r > 255);
                ac = ((a % 16) + (b % 16) + t) > 15;
                ov = ((sa + sb + t) > 127) || ((sa + sb + t) < -128);
                r  = r % 256;
            end
            2: begin // R6 R4 R5
                r  = a - b - c;
                cy = (r < 0);
                ac = ((a % 16) - (b % 16) - c) < 0;
                ov = ((sa - sb - c) > 127) || ((sa - sb - c) < -128);
                r  = (r + 512) % 256;
            end
            3: r = (a + 1) % 256;
            4: r = (a + 255) % 256;
            5: r = a & b;
            6: r = a | b;
            7: r = a ^ b;
            8: r = 0;
            9: r = 255 - a;
            10: r = (a * 2) % 256 + a / 128;
            11: begin r = (a * 2) % 256 + c; cy = a / 128; end
            12: r = a / 2 + (a % 2) * 128;
            13: begin r = a / 2 + c * 128; cy = a % 2; end
            14: begin
                t = a;
                if ((t % 16) > 9 || h != 0) t = t + 6;
                if (t > 255) begin cy = 1; t = t - 256; end
                if ((t / 16) > 9 || cy != 0) t = t + 96;
                if (t > 255) begin cy = 1; t = t - 256; end
                r = t;
            end
            default: r = a;
        endcase
        t = 0;
        for (int k = 0; k < 8; k++) t = t ^ ((r >> k) & 1);
        return {r[7:0], cy[0], ac[0], ov[0], t[0]};
    endfunction

    function automatic string op_tag(int op);
        case (op)
            0, 1: return "R3";
            2: return "R6";
            3, 4: return "R8";
            5, 6, 7, 8, 9: return "R9";
            10, 11, 12, 13: return "R10";
            14: return "R11";
            default: return "R12";
        endcase
    endfunction

    // Driver: one operation per clock, applied on the falling edge (R2).
    task automatic drive(int op, int a, int b, int c, int h, int v);
        @(negedge clk);
        op_i = op[3:0]; acc_i = a[7:0]; src_i = b[7:0];
        cy_i = c[0]; ac_i = h[0]; ov_i = v[0];
        exp_q.push_back(model(op, a, b, c, h, v));
        op_q.push_back(op);
    endtask

    task automatic fld(string req, string name, int got, int exp);
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, name, got, exp);
        end
    endtask

    // Monitor: each result is due one edge after its inputs (R2).
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (rst_n && exp_q.size() > 0) begin
                logic [11:0] e;
                int o;
                int f0;
                string arith_tag;
                e = exp_q.pop_front();
                o = op_q.pop_front();
                f0 = n_fail;
                arith_tag = (o <= 2) ? "" : op_tag(o);
                n_chk++;
                fld(op_tag(o), "res", res_o, e[11:4]);
                fld(op_tag(o), "cy", cy_o, e[3]);
                fld((o <= 2) ? "R4" : arith_tag, "ac", ac_o, e[2]);
                fld((o <= 2) ? "R5" : arith_tag, "ov", ov_o, e[1]);
                fld("R7", "par", par_o, e[0]);
                if (n_fail > f0 + 1) n_fail = f0 + 1;
            end
        end
    end

    initial begin
        int pa[12] = '{8'h7F, 8'hFF, 8'h80, 8'h02, 8'h0F, 8'h00,
                       8'h45, 8'h99, 8'h9A, 8'h5A, 8'h38, 8'hA0};
        int pb[12] = '{8'h01, 8'h01, 8'h80, 8'h05, 8'h01, 8'h00,
                       8'h47, 8'h01, 8'h00, 8'hA5, 8'h49, 8'h60};
        repeat (3) @(negedge clk);
        // R1: reset state
        n_chk++;
        if ({res_o, cy_o, ac_o, ov_o, par_o} != 12'h000) begin
            n_fail++;
            $display("FAIL R1 reset actual=%0h expected=0", {res_o, cy_o, ac_o, ov_o, par_o});
        end
        rst_n = 1'b1;
        for (int i = 0; i < 12; i++)
            for (int op = 0; op < 16; op++)
                for (int f = 0; f < 8; f++)
                    drive(op, pa[i], pb[i], f & 1, (f >> 1) & 1, (f >> 2) & 1);
        // R11: BCD add then adjust sequences, e.g. 45h+47h -> 92h, 99h+99h -> 98h with CY
        drive(14, 8'h8C, 0, 0, 1, 0);
        drive(14, 8'h32, 0, 1, 1, 0);
        drive(14, 8'hFA, 0, 0, 0, 0);
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule